// File: doc/BRIEF.md
# Next-PC and Branch/Jump Unit

This block holds the program counter of a single-cycle core whose instruction memory is addressed by word. On every rising clock edge it loads the address of the next instruction. The source of that address is chosen by two separate two-bit controls from the decoder. The first control picks the PC source: the sequential path, a direct jump, or a jump through a register. The second control names the branch test that applies on the sequential path: none, equal, not equal, or "rs negative".

The unit compares the two register operands on its own. It adds the sign-extended immediate to PC+1 to form the branch target, and zero-extends the jump field into a word address. Instruction fetch, decoding and the register file sit outside the block.

There is no data stream in this block, so it has no valid/ready handshake. All pins are plain control and status signals, and the PC changes on every clock edge while reset is released. The low four PC bits are also driven onto a separate port for indicator LEDs.

Top module: `nextpc_unit`

## Requirements
- R1: An active-low reset `rst_n` clears the PC to 0 at once, without waiting for a clock edge, and holds it at 0 while low.
- R2: With `src_sel`=00 and `cond_sel`=00, each rising edge loads PC+1, wrapping modulo 2^32.
- R3: With `src_sel`=00 and `cond_sel`=01 (equal test), the PC becomes PC+1+sext(`imm`) when `rs_val`==`rt_val`, otherwise PC+1.
- R4: With `src_sel`=00 and `cond_sel`=10 (not-equal test), the PC becomes PC+1+sext(`imm`) when `rs_val`!=`rt_val`, otherwise PC+1.
- R5: With `src_sel`=00 and `cond_sel`=11 (negative test), the PC becomes PC+1+sext(`imm`) when bit 31 of `rs_val` is 1, otherwise PC+1. `rt_val` plays no part in this test.
- R6: The 16-bit `imm` is sign-extended from bit 15, so a taken branch can move backwards. Target arithmetic wraps modulo 2^32.
- R7: With `src_sel`=01, the PC becomes the 26-bit `jfield` zero-extended to 32 bits.
- R8: With `src_sel`=10, the PC becomes `rs_val`.
- R9: With `src_sel`=11 (spare code), the PC becomes PC+1 whatever the branch test would give.
- R10: With `src_sel` equal to 01 or 10, `cond_sel` and the comparison result have no effect on the next PC.
- R11: `pc_leds` always equals bits 3:0 of `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_sel | input | 2 | Branch test: 00 none, 01 equal, 10 not equal, 11 rs negative |
| src_sel | input | 2 | PC source: 00 sequential/branch, 01 jump, 10 register, 11 spare (PC+1) |
| rs_val | input | 32 | First register operand; jump-register address |
| rt_val | input | 32 | Second register operand for the equality tests |
| imm | input | 16 | Signed branch offset in words |
| jfield | input | 26 | Jump target word address |
| pc | output | 32 | Current program counter |
| pc_leds | output | 4 | Low four bits of the PC |

## Verification
The branch test and the PC-source choice are evaluated in the same cycle. A true comparison can therefore coincide with a jump, a register jump or the spare code. The bench provokes this by driving `rs_val` equal to `rt_val`, or negative, while `src_sel` is 01, 10 or 11. It judges the outcome against a behavioural model in which the source control always overrides the test. Randomised cycles force operand equality about half the time, so these collisions recur across many PC values, including backward offsets that wrap through zero.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_EQ   = 2'b01,
    BR_NE   = 2'b10,
    BR_LTZ  = 2'b11
  } br_kind_e;

  typedef enum logic [1:0] {
    PC_SEQ   = 2'b00,
    PC_JUMP  = 2'b01,
    PC_REG   = 2'b10,
    PC_SPARE = 2'b11
  } pc_src_e;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  br_kind_e            kind,
  input  logic [DATA_W-1:0]   opa,
  input  logic [DATA_W-1:0]   opb,
  output logic                taken
);

  logic same;
  assign same = (opa == opb);

  always_comb begin
    unique case (kind)
      BR_EQ:   taken = same;
      BR_NE:   taken = !same;
      BR_LTZ:  taken = opa[DATA_W-1];
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int JMP_W  = 26
) (
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [IMM_W-1:0]  offset,
  input  logic [JMP_W-1:0]  jfield,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] br_addr,
  output logic [ADDR_W-1:0] jmp_addr
);

  localparam int SEXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] off_ext;

  assign off_ext  = {{SEXT_W{offset[IMM_W-1]}}, offset};
  assign seq_addr = cur_pc + ADDR_W'(1);
  assign br_addr  = seq_addr + off_ext;

  generate
    if (ADDR_W > JMP_W) begin : g_zext
      assign jmp_addr = {{(ADDR_W-JMP_W){1'b0}}, jfield};
    end else begin : g_trunc
      assign jmp_addr = jfield[ADDR_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  pc_src_e           src,
  input  logic              taken,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [ADDR_W-1:0] jmp_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [ADDR_W-1:0] next_pc
);

  always_comb begin
    unique case (src)
      PC_SEQ:  next_pc = taken ? br_addr : seq_addr;
      PC_JUMP: next_pc = jmp_addr;
      PC_REG:  next_pc = reg_addr;
      default: next_pc = seq_addr;
    endcase
  end

endmodule

// File: rtl/npc_reg.sv
module npc_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> q == '0);

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int JMP_W  = 26,
  parameter int LED_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cond_sel,
  input  logic [1:0]        src_sel,
  input  logic [ADDR_W-1:0] rs_val,
  input  logic [ADDR_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JMP_W-1:0]  jfield,
  output logic [ADDR_W-1:0] pc,
  output logic [LED_W-1:0]  pc_leds
);

  br_kind_e          kind;
  pc_src_e           src;
  logic              taken;
  logic [ADDR_W-1:0] seq_addr, br_addr, jmp_addr, next_pc;

  assign kind = br_kind_e'(cond_sel);
  assign src  = pc_src_e'(src_sel);

  npc_cond #(.DATA_W(ADDR_W)) u_cond (
    .kind (kind),
    .opa  (rs_val),
    .opb  (rt_val),
    .taken(taken)
  );

  npc_target #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .JMP_W(JMP_W)) u_target (
    .cur_pc  (pc),
    .offset  (imm),
    .jfield  (jfield),
    .seq_addr(seq_addr),
    .br_addr (br_addr),
    .jmp_addr(jmp_addr)
  );

  npc_select #(.ADDR_W(ADDR_W)) u_select (
    .src     (src),
    .taken   (taken),
    .seq_addr(seq_addr),
    .br_addr (br_addr),
    .jmp_addr(jmp_addr),
    .reg_addr(rs_val),
    .next_pc (next_pc)
  );

  npc_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (next_pc),
    .q    (pc)
  );

  assign pc_leds = pc[LED_W-1:0];

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b00 && !taken) |=> pc == $past(pc) + ADDR_W'(1));

  // R3
  taken_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b00 && taken) |=>
      pc == $past(pc) + ADDR_W'(1) + {{(ADDR_W-IMM_W){$past(imm[IMM_W-1])}}, $past(imm)});

  // R5
  ltz_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 2'b11 && src_sel == 2'b00 && rs_val[ADDR_W-1]) |=> pc != $past(pc) + ADDR_W'(1) || $past(imm) == '0);

  // R7
  direct_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel == 2'b01 |=> pc == ADDR_W'($past(jfield)));

  // R8
  reg_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel == 2'b10 |=> pc == $past(rs_val));

  // R9
  spare_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel == 2'b11 |=> pc == $past(pc) + ADDR_W'(1));

endmodule

// File: tb/test_nextpc_unit.sv
module test_nextpc_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [1:0]  cond_sel = '0;
  logic [1:0]  src_sel = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [15:0] imm = '0;
  logic [25:0] jfield = '0;
  logic [31:0] pc;
  logic [3:0]  pc_leds;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_pc;

  always #4 clk = ~clk;

  nextpc_unit i_nextpc_unit (
    .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel), .src_sel(src_sel),
    .rs_val(rs_val), .rt_val(rt_val), .imm(imm), .jfield(jfield),
    .pc(pc), .pc_leds(pc_leds)
  );

  function automatic logic [31:0] ref_next(logic [31:0] p, logic [1:0] c, logic [1:0] s,
      logic [31:0] a, logic [31:0] b, logic [15:0] o, logic [25:0] j);
    bit hit;
    longint t;
    if (s == 2'd1) return {6'd0, j};
    if (s == 2'd2) return a;
    if (s == 2'd3) return p + 1;
    case (c)
      2'd1: hit = (a == b);
      2'd2: hit = (a != b);
      2'd3: hit = a[31];
      default: hit = 0;
    endcase
    t = longint'(p) + 1 + (hit ? longint'($signed(o)) : 0);
    return t[31:0];
  endfunction

  task automatic check(string tag, logic [31:0] exp);
    checks++;
    if (pc !== exp) begin
      errors++;
      $display("FAIL %s: pc=%h expected %h", tag, pc, exp);
    end
    checks++;
    if (pc_leds !== exp[3:0]) begin
      errors++;
      $display("FAIL R11 (%s): pc_leds=%h expected %h", tag, pc_leds, exp[3:0]);
    end
  endtask

  task automatic step(string tag, logic [1:0] c, logic [1:0] s, logic [31:0] a,
                      logic [31:0] b, logic [15:0] o, logic [25:0] j);
    logic [31:0] exp;
    cond_sel = c; src_sel = s; rs_val = a; rt_val = b; imm = o; jfield = j;
    exp = ref_next(model_pc, c, s, a, b, o, j);
    @(posedge clk);
    @(negedge clk);
    check(tag, exp);
    model_pc = exp;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, actual running expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    #1 check("R1", 32'd0);
    @(negedge clk); @(negedge clk);
    check("R1", 32'd0);
    rst_n = 1'b1;
    model_pc = 0;

    step("R2", 2'b00, 2'b00, 0, 0, 16'h0005, 0);
    step("R2", 2'b00, 2'b00, 0, 0, 16'h0005, 0);
    step("R3", 2'b01, 2'b00, 32'h55, 32'h55, 16'h0010, 0);
    step("R3", 2'b01, 2'b00, 32'h55, 32'h56, 16'h0010, 0);
    step("R4", 2'b10, 2'b00, 32'h7, 32'h9, 16'h0003, 0);
    step("R4", 2'b10, 2'b00, 32'h7, 32'h7, 16'h0003, 0);
    step("R5", 2'b11, 2'b00, 32'h8000_0000, 32'h8000_0000, 16'h0004, 0);
    step("R5", 2'b11, 2'b00, 32'h7FFF_FFFF, 32'h1, 16'h0004, 0);
    step("R6", 2'b01, 2'b00, 32'h1, 32'h1, 16'hFFF0, 0);
    step("R7", 2'b01, 2'b01, 32'h3, 32'h3, 16'h0040, 26'h3FF_FFFF);
    step("R10", 2'b01, 2'b01, 32'h0, 32'h0, 16'h7FFF, 26'h000_0123);
    step("R8", 2'b00, 2'b10, 32'hFFFF_FFFE, 0, 0, 0);
    step("R2", 2'b00, 2'b00, 0, 0, 0, 0);
    step("R6", 2'b00, 2'b00, 0, 0, 0, 0);
    step("R10", 2'b01, 2'b10, 32'h0000_00A0, 32'h0000_00A0, 16'h0100, 0);
    step("R9", 2'b01, 2'b11, 32'h1, 32'h1, 16'h0100, 0);
    step("R9", 2'b11, 2'b11, 32'h8000_0000, 0, 16'h0100, 0);
    step("R6", 2'b11, 2'b00, 32'hF000_0000, 0, 16'h8000, 0);

    #2 rst_n = 1'b0;
    #1 check("R1", 32'd0);
    @(negedge clk);
    check("R1", 32'd0);
    rst_n = 1'b1;
    model_pc = 0;

    for (int k = 0; k < 400; k++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom_range(0, 1) == 1) ? a : $urandom;
      step("R10", 2'($urandom), 2'($urandom), a, b, 16'($urandom), 26'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule